// File: doc/BRIEF.md
# Two-Level LRU Victim Selector with Way Pinning

This block holds the replacement history of a 64-set, 8-way cache and names the way to evict when a miss arrives. The eight ways of a set form two groups of four. One bit per set records which group was used less recently. Inside each group a three-bit pseudo-LRU tree records which way within that group was used less recently. Every hit, and every fill made on a miss, steers all of these bits away from the way just touched.

Software may pin up to four ways of each set by writing a per-set lock mask. The selector walks the replacement state and skips locked ways. Within a group it moves to the other pair or to the other way of a pair. If the group it prefers is fully locked, it falls back to the best unlocked way of the other group. A lock write that would pin more than four ways is dropped. Tag comparison and data movement are left to the surrounding cache.

The victim outputs are combinational from the registered state of the set on `set_idx`. Updates to replacement state and lock masks take effect at the next rising clock edge.

Top module: `lru_victim_sel`

## Requirements
- R1: After reset every set has all replacement bits clear and no ways locked. Each set then offers way 0 as its victim.
- R2: Bit 2 of a way number selects its group: ways 0-3 are group 0 and ways 4-7 are group 1. After a hit on way w in a set, that set's next victim lies in the group that does not contain w, unless that group is fully locked.
- R3: Each group keeps a root bit that chooses its pair (way bits [1:0] 0-1 or 2-3) and one bit per pair that chooses the way. An access points the root and the pair bit of its own pair away from the accessed way. Eight back-to-back misses on an unlocked set, starting from reset, evict ways 0, 4, 2, 6, 1, 5, 3, 7 in that order.
- R4: A miss_req with hit_valid low updates the set's state as an access to the victim it was offered in that cycle.
- R5: A way whose lock bit is set (bit i of the mask pins way i) is never offered as victim.
- R6: Inside a group, if both ways of the preferred pair are locked, the other pair is used. If the preferred way of a pair is locked, its partner is used.
- R7: If every way of the preferred group is locked, the victim comes from the other group, using that group's own tree.
- R8: A lock write whose mask has more than four bits set is rejected, and the set's mask stays as it was.
- R9: A lock write with four or fewer bits set replaces the set's mask, and a zero mask unpins every way.
- R10: Updates and lock writes touch only the set on set_idx, and other sets keep their state.
- R11: When hit_valid and miss_req are both high, only the hit way updates the state.
- R12: no_victim is high only when all eight ways of the addressed set are locked, which cannot occur while the lock limit is four.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| set_idx | input | 6 | Set addressed by this cycle's update, lock write and victim query |
| hit_valid | input | 1 | A hit occurred on hit_way in the addressed set |
| hit_way | input | 3 | Way that hit |
| miss_req | input | 1 | A miss occurred; the offered victim is filled and marked recent |
| lock_wr | input | 1 | Write lock_mask to the addressed set |
| lock_mask | input | 8 | New pin mask, bit i pins way i |
| victim_way | output | 3 | Way to evict in the addressed set |
| no_victim | output | 1 | Every way of the addressed set is locked |

## Verification
On every cycle the assertions check that the offered victim is never a pinned way and that no stored mask holds more than four bits. They also check that the way just hit is not the next victim of the same set, that a rejected lock write leaves the mask unchanged, and that no_victim stays low. The exact eviction order, the pair and group fallbacks, the separation between sets and the priority of a hit over a coincident miss are shown only by the bench's scenarios. The bench compares each cycle's victim with a model built from the requirements.

// File: rtl/lru_victim_pkg.sv
// Shared types for the two-level LRU victim selector.
// Assumes a fixed 8-way geometry: two groups of four ways.
package lru_victim_pkg;
    localparam int NUM_WAYS    = 8;
    localparam int GROUP_WAYS  = 4;
    localparam int WAY_W       = $clog2(NUM_WAYS);

    // Per-set replacement record: group bit plus one 3-bit tree per group.
    // Tree bit 0 picks the pair, bit 1 the way in pair 0, bit 2 the way in pair 1.
    typedef struct packed {
        logic       grp;
        logic [2:0] tree1;
        logic [2:0] tree0;
    } repl_state_t;
endpackage

// File: rtl/lru_group_pick.sv
// Lock-aware pseudo-LRU walk over one group of four ways.
// Assumes the tree encoding of repl_state_t; reports whether any way is free.
module lru_group_pick (
    input  logic [2:0] tree,
    input  logic [3:0] lock,
    output logic [1:0] way,
    output logic       avail
);
    logic [1:0] pair_free;
    logic       use_pair;
    logic       pref_bit;
    logic [1:0] first_idx;

    // Walk the tree, stepping aside from locked pairs and ways.
    always_comb begin
        pair_free[0] = ~(lock[0] & lock[1]);
        pair_free[1] = ~(lock[2] & lock[3]);
        use_pair     = pair_free[tree[0]] ? tree[0] : ~tree[0];
        pref_bit     = use_pair ? tree[2] : tree[1];
        first_idx    = {use_pair, pref_bit};
        way          = lock[first_idx] ? {use_pair, ~pref_bit} : first_idx;
        avail        = ~&lock;
    end
endmodule

// File: rtl/lru_touch.sv
// Computes the replacement record after an access to one way.
// Assumes way bit 2 selects the group; points every bit on the path away.
module lru_touch
    import lru_victim_pkg::*;
(
    input  repl_state_t      cur,
    input  logic [WAY_W-1:0] way,
    output repl_state_t      nxt
);
    logic [2:0] t_in;
    logic [2:0] t_out;

    // Update the group bit and the tree of the accessed group.
    always_comb begin
        nxt      = cur;
        nxt.grp  = ~way[2];
        t_in     = way[2] ? cur.tree1 : cur.tree0;
        t_out    = t_in;
        t_out[0] = ~way[1];
        if (way[1]) t_out[2] = ~way[0];
        else        t_out[1] = ~way[0];
        if (way[2]) nxt.tree1 = t_out;
        else        nxt.tree0 = t_out;
    end
endmodule

// File: rtl/lock_guard.sv
// Accepts a new pin mask only if it holds at most MAX_LOCKS bits.
// Assumes the caller applies nxt on every cycle; rejected writes keep cur.
module lock_guard #(
    parameter int WAYS      = 8,
    parameter int MAX_LOCKS = 4
) (
    input  logic [WAYS-1:0] cur,
    input  logic [WAYS-1:0] req_mask,
    input  logic            wr,
    output logic [WAYS-1:0] nxt
);
    localparam int CNT_W = $clog2(WAYS + 1);
    logic [CNT_W-1:0] pop;

    // Count requested pins and keep the old mask if the count is too high.
    always_comb begin
        pop = '0;
        for (int i = 0; i < WAYS; i++) pop = pop + CNT_W'(req_mask[i]);
        nxt = (wr && (int'(pop) <= MAX_LOCKS)) ? req_mask : cur;
    end
endmodule

// File: rtl/lru_victim_sel.sv
// Per-set two-level LRU replacement with way pinning.
// Assumes one access per cycle; victim outputs are combinational from state.
module lru_victim_sel
    import lru_victim_pkg::*;
#(
    parameter int NUM_SETS  = 64,
    parameter int MAX_LOCKS = 4,
    localparam int SET_W    = $clog2(NUM_SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] set_idx,
    input  logic             hit_valid,
    input  logic [2:0]       hit_way,
    input  logic             miss_req,
    input  logic             lock_wr,
    input  logic [7:0]       lock_mask,
    output logic [2:0]       victim_way,
    output logic             no_victim
);
    repl_state_t          st_q [NUM_SETS];
    logic [NUM_WAYS-1:0]  lk_q [NUM_SETS];

    repl_state_t          st_cur;
    repl_state_t          st_nxt;
    logic [NUM_WAYS-1:0]  lk_cur;
    logic [NUM_WAYS-1:0]  lk_nxt;
    logic [1:0]           grp_way [2];
    logic [1:0]           grp_avail;
    logic                 sel_grp;
    logic [WAY_W-1:0]     touch_way;
    logic                 touch_en;

    // Read the addressed set's records.
    always_comb begin
        st_cur = st_q[set_idx];
        lk_cur = lk_q[set_idx];
    end

    // One lock-aware picker per group.
    for (genvar g = 0; g < 2; g++) begin : g_pick
        lru_group_pick u_pick (
            .tree  (g == 0 ? st_cur.tree0 : st_cur.tree1),
            .lock  (lk_cur[g*GROUP_WAYS +: GROUP_WAYS]),
            .way   (grp_way[g]),
            .avail (grp_avail[g])
        );
    end

    // Prefer the least recently used group, fall back if it is fully pinned.
    always_comb begin
        sel_grp    = grp_avail[st_cur.grp] ? st_cur.grp : ~st_cur.grp;
        victim_way = {sel_grp, grp_way[sel_grp]};
        no_victim  = ~|grp_avail;
        touch_en   = hit_valid | (miss_req & ~no_victim);
        touch_way  = hit_valid ? hit_way : victim_way;
    end

    lru_touch u_touch (
        .cur (st_cur),
        .way (touch_way),
        .nxt (st_nxt)
    );

    lock_guard #(
        .WAYS      (NUM_WAYS),
        .MAX_LOCKS (MAX_LOCKS)
    ) u_guard (
        .cur      (lk_cur),
        .req_mask (lock_mask),
        .wr       (lock_wr),
        .nxt      (lk_nxt)
    );

    // Store replacement and lock state for the addressed set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                st_q[s] <= '0;
                lk_q[s] <= '0;
            end
        end else begin
            if (touch_en) st_q[set_idx] <= st_nxt;
            lk_q[set_idx] <= lk_nxt;
        end
    end
endmodule

// File: rtl/lru_victim_chk.sv
// Property checker for lru_victim_sel, attached by bind below.
module lru_victim_chk #(
    parameter int MAX_LOCKS = 4,
    parameter int SET_W     = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SET_W-1:0] set_idx,
    input logic             hit_valid,
    input logic             miss_req,
    input logic [2:0]       hit_way,
    input logic             lock_wr,
    input logic [7:0]       lock_mask,
    input logic [7:0]       lk_cur,
    input logic [2:0]       victim_way,
    input logic             no_victim
);
    // R5
    pinned_way_skipped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !no_victim |-> !lk_cur[victim_way]);

    // R8
    mask_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(lk_cur) <= MAX_LOCKS);

    // R8
    reject_keeps_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_wr && $countones(lock_mask) > MAX_LOCKS)
        |=> ((set_idx == $past(set_idx)) |-> (lk_cur == $past(lk_cur))));

    // R2
    hit_not_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |=> ((set_idx == $past(set_idx)) |-> (victim_way != $past(hit_way))));

    // R12
    always_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_req || !miss_req) |-> !no_victim);
endmodule

bind lru_victim_sel lru_victim_chk #(
    .MAX_LOCKS (MAX_LOCKS),
    .SET_W     (SET_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_idx    (set_idx),
    .hit_valid  (hit_valid),
    .miss_req   (miss_req),
    .hit_way    (hit_way),
    .lock_wr    (lock_wr),
    .lock_mask  (lock_mask),
    .lk_cur     (lk_cur),
    .victim_way (victim_way),
    .no_victim  (no_victim)
);

// File: tb/test_lru_victim_sel.sv
// Self-checking bench: directed corners plus seeded random traffic.
module test_lru_victim_sel;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [5:0] set_idx;
    logic       hit_valid;
    logic [2:0] hit_way;
    logic       miss_req;
    logic       lock_wr;
    logic [7:0] lock_mask;
    logic [2:0] victim_way;
    logic       no_victim;

    int checks = 0;
    int errors = 0;

    logic [6:0] m_st [64];   // {grp, tree1[2:0], tree0[2:0]}
    logic [7:0] m_lk [64];

    always #4 clk = ~clk;

    lru_victim_sel i_lru_victim_sel (
        .clk(clk), .rst_n(rst_n), .set_idx(set_idx), .hit_valid(hit_valid),
        .hit_way(hit_way), .miss_req(miss_req), .lock_wr(lock_wr),
        .lock_mask(lock_mask), .victim_way(victim_way), .no_victim(no_victim)
    );

    // Victim within one group per R3/R6: returns {found, way[1:0]}.
    function automatic logic [2:0] grp_pick(input logic [2:0] t, input logic [3:0] l);
        logic p, b;
        if (&l) return 3'b000;
        p = t[0];
        if (l[{p, 1'b0}] && l[{p, 1'b1}]) p = ~p;
        b = p ? t[2] : t[1];
        if (l[{p, b}]) b = ~b;
        return {1'b1, p, b};
    endfunction

    // Model victim per R2/R7.
    function automatic logic [3:0] m_pick(input int s);
        logic [2:0] r0, r1;
        logic g;
        r0 = grp_pick(m_st[s][2:0], m_lk[s][3:0]);
        r1 = grp_pick(m_st[s][5:3], m_lk[s][7:4]);
        if (!r0[2] && !r1[2]) return 4'b1000;
        g = m_st[s][6];
        if (!(g ? r1[2] : r0[2])) g = ~g;
        return {1'b0, g, (g ? r1[1:0] : r0[1:0])};
    endfunction

    // Model access update per R3.
    function automatic logic [6:0] m_touch(input logic [6:0] st, input logic [2:0] w);
        logic [2:0] t;
        logic [6:0] r;
        r = st;
        t = w[2] ? st[5:3] : st[2:0];
        t[0] = ~w[1];
        if (w[1]) t[2] = ~w[0]; else t[1] = ~w[0];
        r[6] = ~w[2];
        if (w[2]) r[5:3] = t; else r[2:0] = t;
        return r;
    endfunction

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got nv=%0b way=%0d expected nv=%0b way=%0d",
                     tag, act[3], act[2:0], exp[3], exp[2:0]);
        end
    endtask

    // One cycle: drive, compare victim, clock, update model.
    task automatic cyc(input string tag, input int s, input logic hv, input logic [2:0] hw,
                       input logic mr, input logic lw, input logic [7:0] lm);
        logic [3:0] exp;
        int cnt;
        @(negedge clk);
        set_idx = 6'(s); hit_valid = hv; hit_way = hw; miss_req = mr;
        lock_wr = lw; lock_mask = lm;
        #1;
        exp = m_pick(s);
        check(tag, {no_victim, victim_way}, exp);
        @(posedge clk);
        #1;
        if (hv) m_st[s] = m_touch(m_st[s], hw);
        else if (mr && !exp[3]) m_st[s] = m_touch(m_st[s], exp[2:0]);
        cnt = $countones(lm);
        if (lw && cnt <= 4) m_lk[s] = lm;
    endtask

    task automatic expect_way(input string tag, input int s, input logic [2:0] w);
        @(negedge clk);
        set_idx = 6'(s); hit_valid = 0; miss_req = 0; lock_wr = 0;
        #1;
        check(tag, {no_victim, victim_way}, {1'b0, w});
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: got hang expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [2:0] order [8];
        order = '{3'd0, 3'd4, 3'd2, 3'd6, 3'd1, 3'd5, 3'd3, 3'd7};
        void'($urandom(32'd20240611));
        for (int s = 0; s < 64; s++) begin m_st[s] = '0; m_lk[s] = '0; end
        rst_n = 0; set_idx = 0; hit_valid = 0; hit_way = 0; miss_req = 0;
        lock_wr = 0; lock_mask = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;

        // R1: reset state of several sets
        expect_way("R1", 0, 3'd0);
        expect_way("R1", 63, 3'd0);

        // R3 and R4: eviction order from reset under repeated misses
        for (int i = 0; i < 8; i++) begin
            expect_way("R3", 1, order[i]);
            cyc("R4", 1, 0, 0, 1, 0, 8'h00);
        end
        expect_way("R3", 1, 3'd0);

        // R2: hit moves the victim to the other group
        cyc("R2", 2, 1, 3'd1, 0, 0, 8'h00);
        expect_way("R2", 2, 3'd4);
        // R11: coincident hit and miss, only hit way counts
        cyc("R11", 2, 1, 3'd6, 1, 0, 8'h00);
        expect_way("R11", 2, 3'd2);

        // R6: pinned way and pinned pair within preferred group
        cyc("R9", 3, 0, 0, 0, 1, 8'h01);
        expect_way("R6", 3, 3'd1);
        cyc("R9", 3, 0, 0, 0, 1, 8'h03);
        expect_way("R6", 3, 3'd2);
        // R7: whole preferred group pinned
        cyc("R9", 3, 0, 0, 0, 1, 8'h0F);
        expect_way("R7", 3, 3'd4);
        // R5: misses never hit a pinned way
        for (int i = 0; i < 6; i++) cyc("R5", 3, 0, 0, 1, 0, 8'h00);
        // R8: five-bit mask rejected, ways 4-7 still free, 0-3 still pinned
        cyc("R8", 4, 0, 0, 0, 1, 8'h0F);
        cyc("R8", 4, 0, 0, 0, 1, 8'h1F);
        expect_way("R8", 4, 3'd4);
        cyc("R8", 4, 0, 0, 0, 1, 8'hFF);
        expect_way("R8", 4, 3'd4);
        // R9: zero mask unpins
        cyc("R9", 4, 0, 0, 0, 1, 8'h00);
        expect_way("R9", 4, 3'd0);
        // R10: other sets untouched by all the above
        expect_way("R10", 5, 3'd0);
        expect_way("R10", 0, 3'd0);
        // R12: no_victim stays low with a full legal lock
        cyc("R12", 6, 0, 0, 0, 1, 8'hF0);
        expect_way("R12", 6, 3'd0);

        // Random traffic over a few sets, compared against the model
        for (int i = 0; i < 4000; i++) begin
            int s;
            logic [7:0] m;
            s = int'($urandom_range(0, 7));
            m = 8'($urandom);
            if ($urandom_range(0, 1) == 0) m = m & 8'($urandom);
            cyc("R5", s, ($urandom_range(0, 2) == 0), 3'($urandom),
                ($urandom_range(0, 1) == 0), ($urandom_range(0, 7) == 0), m);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule